// File: doc/BRIEF.md
# PCIe Enhanced-Configuration Window Decoder

This block keeps the 64-bit base register that places the memory-mapped PCIe configuration window in the physical address map. Configuration software writes the register through a dword-wide port with byte enables. The register holds an enable bit, a two-bit size code and the base address bits. From these the block derives the window base, the address mask, the window length and the first address of the 32-bit PCI memory hole, which begins directly after the window.

A size code selects a 256 MiB, 128 MiB or 64 MiB window. A smaller window unmasks one or two more base bits, so it can sit on a finer boundary. The fourth code is reserved and turns the window off. The decoded values are held in registers. They are refreshed one clock after any write that changes a byte of the base register.

A combinational comparator checks every memory access address against the decoded window. On a hit it splits the address into bus, device, function and register offset. The bus number is narrowed to the number of buses that fit in the selected window.

Top module: `ecam_window_dec`

## Requirements
- R1: After reset the window is disabled (`win_en`=0), the size code is 256 MiB (`win_size`=00), `win_base` is the default base 0xB000_0000, `win_len` is 0x1000_0000, `hole_start` is 0xB000_0000, and no access hits.
- R2: The base register occupies two dwords. The low dword is at dword index `CFG_OFS/4` (default 0x018) and holds enable in bit 0, the size code in bits [2:1] and base bits [31:26] in bits [31:26]. The next dword holds base bits [35:32] in bits [3:0]. A write changes only the bytes whose `cfg_be` bit is set. A write to any other dword, or one with all byte enables clear, leaves the decode unchanged.
- R3: A write presented at clock edge k appears on the decode outputs after edge k+1. The outputs still show the old decode between edges k and k+1.
- R4: Size code 00 gives a 256 MiB window: `win_len`=0x1000_0000 and the base is register bits [35:28].
- R5: Size code 01 gives a 128 MiB window: `win_len`=0x0800_0000 and the base is register bits [35:27].
- R6: Size code 10 gives a 64 MiB window: `win_len`=0x0400_0000 and the base is register bits [35:26].
- R7: Size code 11 is reserved. It forces `win_en`=0 and `win_len`=0 whatever the enable bit holds, and no access hits.
- R8: `hole_start` equals `win_base`+`win_len` while the window is enabled, and equals the default base 0xB000_0000 while it is disabled.
- R9: `acc_hit` is 1 exactly when the window is enabled and `win_base` <= `acc_addr` < `win_base`+`win_len`.
- R10: On a hit, `acc_dev`=addr[19:15], `acc_fn`=addr[14:12] and `acc_reg`=addr[11:0]. `acc_bus`=addr[27:20] keeps 8 bits for 256 MiB, the low 7 bits for 128 MiB and the low 6 bits for 64 MiB, with the upper bits zero. On a miss all four fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw | input | 10 | Dword index of the configuration write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_be | input | 4 | Byte enables of the configuration write |
| acc_addr | input | AW (36) | Physical address of the access under test |
| win_en | output | 1 | Window is decoding |
| win_size | output | 2 | Size code currently in effect |
| win_base | output | AW (36) | Masked window base |
| win_len | output | AW (36) | Window length in bytes (0 when reserved) |
| hole_start | output | AW+1 (37) | First address of the 32-bit PCI memory hole |
| acc_hit | output | 1 | Access address falls inside the window |
| acc_bus | output | 8 | Bus number of the hit |
| acc_dev | output | 5 | Device number of the hit |
| acc_fn | output | 3 | Function number of the hit |
| acc_reg | output | 12 | Register offset of the hit |

## Verification
Register images are written for every size code. Some carry base bits below the size's alignment set, to show that those bits are masked away per size. Each image is probed at the first and last byte of the window and one byte on either side, which distinguishes an off-by-one length from a wrong mask. A base with bits above 4 GiB shows whether the upper dword is decoded. Single-byte-enable writes, writes to a neighbouring dword and writes with no enable set show that lanes are isolated. Probes near the top of 128 MiB and 64 MiB windows show whether the bus number is narrowed.

// File: rtl/ecam_pkg.sv
package ecam_pkg;

  // Size code held in register bits [2:1]; the shift from the largest window
  // equals the code, which the decoder relies on.
  typedef enum logic [1:0] {
    SZ_256M = 2'b00,
    SZ_128M = 2'b01,
    SZ_64M  = 2'b10,
    SZ_RSVD = 2'b11
  } win_size_e;

  localparam int EN_BIT       = 0;
  localparam int SZ_LSB       = 1;
  localparam int SZ_MSB       = 2;
  localparam int MAX_WIN_LOG2 = 28;
  localparam int MIN_WIN_LOG2 = 26;

  localparam int BUS_LSB = 20;
  localparam int BUS_W   = 8;
  localparam int DEV_LSB = 15;
  localparam int DEV_W   = 5;
  localparam int FN_LSB  = 12;
  localparam int FN_W    = 3;
  localparam int OFS_W   = 12;

endpackage

// File: rtl/ecam_cfg_reg.sv
module ecam_cfg_reg #(
  parameter int              DW_W  = 10,
  parameter logic [DW_W-1:0] LO_DW = 10'h018,
  parameter logic [63:0]     DEF   = 64'h0000_0000_B000_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [DW_W-1:0] dw_i,
  input  logic [31:0]     wdata_i,
  input  logic [3:0]      be_i,
  output logic [63:0]     reg_o,
  output logic            upd_o
);

  localparam int NLANE = 8;
  localparam int LPD   = 4;

  logic        lo_sel, hi_sel, touch;
  logic [63:0] reg_q, reg_d;
  logic        upd_q;

  assign lo_sel = wr_i && (dw_i == LO_DW);
  assign hi_sel = wr_i && (dw_i == (LO_DW + 1'b1));
  assign touch  = (lo_sel || hi_sel) && (be_i != '0);

  for (genvar b = 0; b < NLANE; b++) begin : g_lane
    localparam int LANE = b % LPD;
    logic lane_we;
    if (b < LPD) begin : g_lo
      assign lane_we = lo_sel & be_i[LANE];
    end else begin : g_hi
      assign lane_we = hi_sel & be_i[LANE];
    end
    assign reg_d[8*b +: 8] = lane_we ? wdata_i[8*LANE +: 8] : reg_q[8*b +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q <= DEF;
      upd_q <= 1'b0;
    end else begin
      if (touch) reg_q <= reg_d;
      upd_q <= touch;
    end
  end

  assign reg_o = reg_q;
  assign upd_o = upd_q;

endmodule

// File: rtl/ecam_dec.sv
module ecam_dec
  import ecam_pkg::*;
#(
  parameter int            AW       = 36,
  parameter logic [AW-1:0] DEF_BASE = 36'h0_B000_0000
) (
  input  logic [63:0]   reg_i,
  output logic          en_o,
  output win_size_e     size_o,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] mask_o,
  output logic [AW-1:0] len_o,
  output logic [AW:0]   hole_o
);

  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic          rsvd;
  logic [5:0]    lg;
  logic [AW-1:0] len_full;
  logic          unused_bits;

  always_comb begin
    size_o   = win_size_e'(reg_i[SZ_MSB:SZ_LSB]);
    rsvd     = (size_o == SZ_RSVD);
    lg       = rsvd ? 6'(MAX_WIN_LOG2)
                    : 6'(MAX_WIN_LOG2) - {4'b0, reg_i[SZ_MSB:SZ_LSB]};
    len_full = ONE << lg;
    mask_o   = ~(len_full - ONE);
    len_o    = rsvd ? '0 : len_full;
    base_o   = reg_i[AW-1:0] & mask_o;
    en_o     = reg_i[EN_BIT] && !rsvd;
    hole_o   = en_o ? ({1'b0, base_o} + {1'b0, len_o}) : {1'b0, DEF_BASE};
  end

  assign unused_bits = ^{reg_i[63:AW], reg_i[MIN_WIN_LOG2-1:SZ_MSB+1]};

endmodule

// File: rtl/ecam_hit.sv
module ecam_hit
  import ecam_pkg::*;
#(
  parameter int AW = 36
) (
  input  logic             en_i,
  input  win_size_e        size_i,
  input  logic [AW-1:0]    base_i,
  input  logic [AW-1:0]    mask_i,
  input  logic [AW-1:0]    addr_i,
  output logic             hit_o,
  output logic [BUS_W-1:0] bus_o,
  output logic [DEV_W-1:0] dev_o,
  output logic [FN_W-1:0]  fn_o,
  output logic [OFS_W-1:0] reg_o
);

  logic             match;
  logic [BUS_W-1:0] bus_keep;

  assign bus_keep = {BUS_W{1'b1}} >> size_i;
  assign match    = en_i && ((addr_i & mask_i) == base_i);

  assign hit_o = match;
  assign bus_o = match ? (addr_i[BUS_LSB +: BUS_W] & bus_keep) : '0;
  assign dev_o = match ? addr_i[DEV_LSB +: DEV_W] : '0;
  assign fn_o  = match ? addr_i[FN_LSB +: FN_W]   : '0;
  assign reg_o = match ? addr_i[OFS_W-1:0]        : '0;

endmodule

// File: rtl/ecam_window_dec.sv
module ecam_window_dec
  import ecam_pkg::*;
#(
  parameter int            AW       = 36,
  parameter logic [11:0]   CFG_OFS  = 12'h060,
  parameter logic [AW-1:0] DEF_BASE = 36'h0_B000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [9:0]       cfg_dw,
  input  logic [31:0]      cfg_wdata,
  input  logic [3:0]       cfg_be,
  input  logic [AW-1:0]    acc_addr,
  output logic             win_en,
  output logic [1:0]       win_size,
  output logic [AW-1:0]    win_base,
  output logic [AW-1:0]    win_len,
  output logic [AW:0]      hole_start,
  output logic             acc_hit,
  output logic [BUS_W-1:0] acc_bus,
  output logic [DEV_W-1:0] acc_dev,
  output logic [FN_W-1:0]  acc_fn,
  output logic [OFS_W-1:0] acc_reg
);

  localparam int          DW_W    = 10;
  localparam logic [9:0]  LO_DW   = CFG_OFS[11:2];
  localparam logic [63:0] DEF_REG = 64'(DEF_BASE);

  logic rst_q1, rst_q2, rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end
  assign rst_int_n = rst_q2;

  logic [63:0] cfg_q;
  logic        upd;

  ecam_cfg_reg #(.DW_W(DW_W), .LO_DW(LO_DW), .DEF(DEF_REG)) u_reg (
    .clk(clk), .rst_n(rst_int_n), .wr_i(cfg_wr), .dw_i(cfg_dw),
    .wdata_i(cfg_wdata), .be_i(cfg_be), .reg_o(cfg_q), .upd_o(upd)
  );

  logic          n_en, r_en;
  win_size_e     n_size, r_size;
  logic [AW-1:0] n_base, n_mask, n_len, r_base, r_mask, r_len;
  logic [AW:0]   n_hole, r_hole;

  ecam_dec #(.AW(AW), .DEF_BASE(DEF_BASE)) u_dec_live (
    .reg_i(cfg_q), .en_o(n_en), .size_o(n_size), .base_o(n_base),
    .mask_o(n_mask), .len_o(n_len), .hole_o(n_hole)
  );

  ecam_dec #(.AW(AW), .DEF_BASE(DEF_BASE)) u_dec_rst (
    .reg_i(DEF_REG), .en_o(r_en), .size_o(r_size), .base_o(r_base),
    .mask_o(r_mask), .len_o(r_len), .hole_o(r_hole)
  );

  logic          en_q, en_d;
  win_size_e     size_q, size_d;
  logic [AW-1:0] base_q, base_d, mask_q, mask_d, len_q, len_d;
  logic [AW:0]   hole_q, hole_d;

  always_comb begin
    en_d   = en_q;
    size_d = size_q;
    base_d = base_q;
    mask_d = mask_q;
    len_d  = len_q;
    hole_d = hole_q;
    if (upd) begin
      en_d   = n_en;
      size_d = n_size;
      base_d = n_base;
      mask_d = n_mask;
      len_d  = n_len;
      hole_d = n_hole;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      en_q   <= r_en;
      size_q <= r_size;
      base_q <= r_base;
      mask_q <= r_mask;
      len_q  <= r_len;
      hole_q <= r_hole;
    end else begin
      en_q   <= en_d;
      size_q <= size_d;
      base_q <= base_d;
      mask_q <= mask_d;
      len_q  <= len_d;
      hole_q <= hole_d;
    end
  end

  assign win_en     = en_q;
  assign win_size   = size_q;
  assign win_base   = base_q;
  assign win_len    = len_q;
  assign hole_start = hole_q;

  ecam_hit #(.AW(AW)) u_hit (
    .en_i(en_q), .size_i(size_q), .base_i(base_q), .mask_i(mask_q),
    .addr_i(acc_addr), .hit_o(acc_hit), .bus_o(acc_bus), .dev_o(acc_dev),
    .fn_o(acc_fn), .reg_o(acc_reg)
  );

endmodule

// File: rtl/ecam_window_dec_chk.sv
module ecam_window_dec_chk #(
  parameter int            AW       = 36,
  parameter logic [AW-1:0] DEF_BASE = 36'h0_B000_0000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr,
  input logic [AW-1:0] acc_addr,
  input logic          win_en,
  input logic [1:0]    win_size,
  input logic [AW-1:0] win_base,
  input logic [AW-1:0] win_len,
  input logic [AW:0]   hole_start,
  input logic          acc_hit,
  input logic [7:0]    acc_bus,
  input logic [4:0]    acc_dev,
  input logic [2:0]    acc_fn,
  input logic [11:0]   acc_reg
);

  // R3: two idle write cycles leave the decode untouched on the next edge
  a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr ##1 !cfg_wr) |=> $stable({win_en, win_size, win_base, win_len, hole_start}));

  // R7: reserved code disables the window with zero length
  a_r7_reserved_off: assert property (@(posedge clk) disable iff (!rst_n)
    (win_size == 2'b11) |-> (!win_en && (win_len == '0)));

  // R8: disabled window puts the hole at the default base
  a_r8_hole_default: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |-> (hole_start == {1'b0, DEF_BASE}));

  // R9: a hit needs an enabled window
  a_r9_hit_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |-> win_en);

  // R9: a hit lies inside the decoded window
  a_r9_hit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |-> ((acc_addr >= win_base) &&
                 ({1'b0, acc_addr} < ({1'b0, win_base} + {1'b0, win_len}))));

  // R10: fields are zero on a miss
  a_r10_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_hit |-> ({acc_bus, acc_dev, acc_fn, acc_reg} == '0));

  // R10: a 64 MiB window never reports more than 6 bus bits
  a_r10_bus_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_hit && (win_size == 2'b10)) |-> (acc_bus[7:6] == 2'b00));

endmodule

bind ecam_window_dec ecam_window_dec_chk #(.AW(AW), .DEF_BASE(DEF_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .acc_addr(acc_addr),
  .win_en(win_en), .win_size(win_size), .win_base(win_base), .win_len(win_len),
  .hole_start(hole_start), .acc_hit(acc_hit), .acc_bus(acc_bus),
  .acc_dev(acc_dev), .acc_fn(acc_fn), .acc_reg(acc_reg)
);

// File: tb/test_ecam_window_dec.sv
module test_ecam_window_dec;

  localparam int         CLK_PERIOD = 10;
  localparam int         AW         = 36;
  localparam logic [9:0] LO         = 10'h018;
  localparam logic [9:0] HI         = 10'h019;
  localparam logic [35:0] DEFB      = 36'h0_B000_0000;

  typedef struct packed {
    logic [31:0] lo;
    logic [31:0] hi;
    logic [35:0] addr;
    logic        hit;
    logic [35:0] base;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'hB000_0001, 32'h0, 36'h0_B000_0000, 1'b1, 36'h0_B000_0000},
    '{32'hB000_0001, 32'h0, 36'h0_BFFF_FFFF, 1'b1, 36'h0_B000_0000},
    '{32'hB000_0001, 32'h0, 36'h0_C000_0000, 1'b0, 36'h0_B000_0000},
    '{32'hB000_0001, 32'h0, 36'h0_AFFF_FFFF, 1'b0, 36'h0_B000_0000},
    '{32'hEC00_0001, 32'h0, 36'h0_E000_0000, 1'b1, 36'h0_E000_0000},
    '{32'hE800_0003, 32'h0, 36'h0_EFFF_FFFF, 1'b1, 36'h0_E800_0000},
    '{32'hE800_0003, 32'h0, 36'h0_E7FF_FFFF, 1'b0, 36'h0_E800_0000},
    '{32'hEC00_0003, 32'h0, 36'h0_F000_0000, 1'b0, 36'h0_E800_0000},
    '{32'hEC00_0005, 32'h0, 36'h0_EFFF_FFFF, 1'b1, 36'h0_EC00_0000},
    '{32'hEC00_0005, 32'h0, 36'h0_EBFF_FFFF, 1'b0, 36'h0_EC00_0000},
    '{32'h0400_0005, 32'h5, 36'h5_07FF_F123, 1'b1, 36'h5_0400_0000},
    '{32'h0400_0005, 32'h5, 36'h0_0400_0000, 1'b0, 36'h5_0400_0000},
    '{32'hB000_0000, 32'h0, 36'h0_B000_0000, 1'b0, 36'h0_B000_0000},
    '{32'hB000_0007, 32'h0, 36'h0_B000_0000, 1'b0, 36'h0_B000_0000}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_wr;
  logic [9:0]    cfg_dw;
  logic [31:0]   cfg_wdata;
  logic [3:0]    cfg_be;
  logic [AW-1:0] acc_addr;
  logic          win_en;
  logic [1:0]    win_size;
  logic [AW-1:0] win_base, win_len;
  logic [AW:0]   hole_start;
  logic          acc_hit;
  logic [7:0]    acc_bus;
  logic [4:0]    acc_dev;
  logic [2:0]    acc_fn;
  logic [11:0]   acc_reg;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecam_window_dec i_ecam_window_dec (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw),
    .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .acc_addr(acc_addr),
    .win_en(win_en), .win_size(win_size), .win_base(win_base),
    .win_len(win_len), .hole_start(hole_start), .acc_hit(acc_hit),
    .acc_bus(acc_bus), .acc_dev(acc_dev), .acc_fn(acc_fn), .acc_reg(acc_reg)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [9:0] dw, input logic [31:0] d,
                           input logic [3:0] be);
    cfg_wr = 1'b1; cfg_dw = dw; cfg_wdata = d; cfg_be = be;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 4'h0;
  endtask

  function automatic logic [35:0] len_of(input logic [1:0] code);
    case (code)
      2'b00:   return 36'h0_1000_0000;
      2'b01:   return 36'h0_0800_0000;
      2'b10:   return 36'h0_0400_0000;
      default: return 36'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] code);
    case (code)
      2'b00:   return "R4";
      2'b01:   return "R5";
      2'b10:   return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_dw = '0; cfg_wdata = '0; cfg_be = '0;
    acc_addr = DEFB;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;

    // R1 reset state
    chk("R1", "win_en",     64'(win_en),     64'd0);
    chk("R1", "win_size",   64'(win_size),   64'd0);
    chk("R1", "win_base",   64'(win_base),   64'(DEFB));
    chk("R1", "win_len",    64'(win_len),    64'h1000_0000);
    chk("R1", "hole_start", 64'(hole_start), 64'(DEFB));
    chk("R1", "acc_hit",    64'(acc_hit),    64'd0);
    @(negedge clk);

    // R3 latency: not visible after the write edge, visible one edge later
    cfg_write(LO, 32'hB000_0001, 4'hF);
    chk("R3", "win_en before update", 64'(win_en), 64'd0);
    @(negedge clk);
    chk("R3", "win_en after update", 64'(win_en), 64'd1);

    // R2 byte lanes
    cfg_write(LO, 32'hFFFF_FF05, 4'b0001);
    @(negedge clk);
    chk("R2", "size after byte0",  64'(win_size), 64'd2);
    chk("R2", "base after byte0",  64'(win_base), 64'h0_B000_0000);
    cfg_write(LO, 32'h40FF_FFFF, 4'b1000);
    @(negedge clk);
    chk("R2", "base after byte3",  64'(win_base), 64'h0_4000_0000);
    chk("R2", "size after byte3",  64'(win_size), 64'd2);
    cfg_write(LO + 10'd2, 32'h0, 4'hF);
    cfg_write(LO, 32'h0, 4'h0);
    @(negedge clk);
    chk("R2", "base after foreign writes", 64'(win_base), 64'h0_4000_0000);
    chk("R2", "en after foreign writes",   64'(win_en),   64'd1);
    chk("R8", "hole 64M at 0x40000000",    64'(hole_start), 64'h0_4400_0000);

    // R10 field split, R9 boundary just past the window
    acc_addr = 36'h0_4000_0000 | (36'h2A << 20) | (36'h1F << 15) | (36'h5 << 12) | 36'hABC;
    #1;
    chk("R9",  "hit inside",  64'(acc_hit), 64'd1);
    chk("R10", "bus",  64'(acc_bus), 64'h2A);
    chk("R10", "dev",  64'(acc_dev), 64'h1F);
    chk("R10", "fn",   64'(acc_fn),  64'h5);
    chk("R10", "reg",  64'(acc_reg), 64'hABC);
    acc_addr = 36'h0_4400_0000;
    #1;
    chk("R9",  "miss past end", 64'(acc_hit), 64'd0);
    chk("R10", "fields on miss", 64'({acc_bus, acc_dev, acc_fn, acc_reg}), 64'd0);
    @(negedge clk);

    // Table sweep over size codes, alignments and edges (R4..R10)
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  code;
      logic        een;
      logic [35:0] elen;
      logic [36:0] ehole;
      logic [7:0]  ebus;
      string       t;
      code  = VECS[i].lo[2:1];
      t     = tag_of(code);
      een   = VECS[i].lo[0] && (code != 2'b11);
      elen  = len_of(code);
      ehole = een ? ({1'b0, VECS[i].base} + {1'b0, elen}) : {1'b0, DEFB};
      ebus  = VECS[i].hit ? (VECS[i].addr[27:20] & (8'hFF >> code)) : 8'h0;
      cfg_write(LO, VECS[i].lo, 4'hF);
      cfg_write(HI, VECS[i].hi, 4'hF);
      @(negedge clk);
      acc_addr = VECS[i].addr;
      #1;
      chk(t,     $sformatf("v%0d win_en", i),   64'(win_en),   64'(een));
      chk(t,     $sformatf("v%0d win_size", i), 64'(win_size), 64'(code));
      chk(t,     $sformatf("v%0d win_base", i), 64'(win_base), 64'(VECS[i].base));
      chk(t,     $sformatf("v%0d win_len", i),  64'(win_len),  64'(elen));
      chk("R8",  $sformatf("v%0d hole", i),     64'(hole_start), 64'(ehole));
      chk("R9",  $sformatf("v%0d hit", i),      64'(acc_hit),  64'(VECS[i].hit));
      chk("R10", $sformatf("v%0d bus", i),      64'(acc_bus),  64'(ebus));
      chk("R10", $sformatf("v%0d dev", i),      64'(acc_dev),
          VECS[i].hit ? 64'(VECS[i].addr[19:15]) : 64'd0);
      chk("R10", $sformatf("v%0d fn", i),       64'(acc_fn),
          VECS[i].hit ? 64'(VECS[i].addr[14:12]) : 64'd0);
      chk("R10", $sformatf("v%0d reg", i),      64'(acc_reg),
          VECS[i].hit ? 64'(VECS[i].addr[11:0]) : 64'd0);
      @(negedge clk);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule